// File: doc/BRIEF.md
# Tile-Grid Puzzle Overlay Generator

This block is a pixel-generation stage for a chained video pipeline. It watches the scan coordinates of a 640x480 raster and paints a three-by-three matrix of square tiles in the middle of the screen. Each tile shows one of two programmable colours depending on its lit/unlit bit. One tile may be marked with a red highlight, drawn as a thin ring, as a solid fill or as a small central dot. White separator lines two pixels wide run between the tiles and around the outside of the matrix. Pixels that fall outside the matrix carry the upstream pixel unchanged.

The incoming pixel is already aligned with the coordinates of two cycles earlier. The block therefore generates its own colour two register stages after the coordinates and mixes it with the incoming pixel of the current cycle. A bypass bit hands the upstream pixel straight through. All settings arrive through a word-addressed write-only slot port. Tile and column positions are found by comparing against fixed boundaries rather than by division, so every region of the screen has the same latency.

Top module: `tile_grid_overlay`

## Requirements
- R1: After reset the bypass bit is 0, all nine tiles are unlit, the cursor is at row 0, column 0 and the ring style is selected. The lit colour is 0x0F0 and the unlit colour is 0x000. While reset is held, pix_out equals pix_in.
- R2: A register changes only in a clock where cs and wr are both high. A write to a word address other than 0, 1, 2, 3 or 0x2000 changes nothing.
- R3: The generated colour for the coordinates presented in cycle n appears on pix_out in cycle n+2. It is combined with the pix_in value present in cycle n+2.
- R4: Bit 0 of word 0x2000 is the bypass bit. When it is 1, pix_out equals pix_in at every position, starting from the cycle after the write.
- R5: The matrix spans x 196..443 and y 116..363. Coordinates outside this window give pix_out = pix_in.
- R6: Inside the window, a pixel whose offset from the window origin, taken modulo 82, is 0 or 1 on either axis is a separator line. It is drawn as 0xFFF.
- R7: Tile (r,c) covers offsets 82*c+2..82*c+81 in x and 82*r+2..82*r+81 in y. Word 0 holds the tile bits, with bit 3*r+c lit. A lit tile shows word 3 bits 11:0 and an unlit tile shows word 3 bits 23:12. Colours are packed R in bits 11:8, G in bits 7:4 and B in bits 3:0.
- R8: Word 1 bits 1:0 give the cursor row and bits 3:2 give the cursor column. A value of 3 in either field removes the highlight.
- R9: Word 2 bits 1:0 select the highlight style. Style 0 paints 0xF00 on the selected tile pixels whose in-tile offset on either axis is 0..2 or 77..79.
- R10: Style 1 paints the whole selected tile 0xF00.
- R11: Style 2 paints 0xF00 where both in-tile offsets are in 32..47. Style 3 paints no highlight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Asynchronous reset, active high |
| x | input | 11 | Horizontal scan coordinate |
| y | input | 11 | Vertical scan coordinate |
| cs | input | 1 | Slot select |
| wr | input | 1 | Write strobe |
| addr | input | 14 | Word address within the slot |
| wdata | input | 32 | Write data |
| pix_in | input | 12 | Upstream pixel, RGB 4:4:4 |
| pix_out | output | 12 | Downstream pixel, RGB 4:4:4 |

## Verification
Some properties are checked on every cycle. Writes without both strobes must leave all settings untouched. A bypass write must hand pix_in through on the next cycle. Coordinates that lay outside the window two cycles earlier must yield pix_in. Coordinates that fell on a separator line two cycles earlier must yield white. These checks share one two-cycle alignment, which pins down the latency in the outside and line regions. The tile colours, the cursor decoding and the shapes of the three highlight styles all depend on the programmed state. Only the bench's scenarios show them: a reference model is compared at the ring, dot and window edges, across the cursor-off codes and under random settings.

// File: rtl/tile_grid_overlay.sv
module tile_grid_overlay #(
  parameter int XW    = 11,
  parameter int CW    = 12,
  parameter int AW    = 14,
  parameter int DW    = 32,
  parameter int ORG_X = 196,
  parameter int ORG_Y = 116,
  parameter int CELL  = 80,
  parameter int GAP   = 2,
  parameter int RING  = 3,
  parameter int DOT   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [XW-1:0] x,
  input  logic [XW-1:0] y,
  input  logic          cs,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] pix_in,
  output logic [CW-1:0] pix_out
);

  localparam int PITCH  = CELL + GAP;
  localparam int SPAN   = 3 * PITCH + GAP;
  localparam int OW     = $clog2(CELL);
  localparam int DOT_LO = (CELL - DOT) / 2;
  localparam int DOT_HI = DOT_LO + DOT;
  localparam logic [CW-1:0] RED   = CW'(12'hF00);
  localparam logic [CW-1:0] WHITE = CW'(12'hFFF);
  localparam logic [AW-1:0] A_CELLS = AW'(0);
  localparam logic [AW-1:0] A_CURS  = AW'(1);
  localparam logic [AW-1:0] A_STYLE = AW'(2);
  localparam logic [AW-1:0] A_COLR  = AW'(3);
  localparam logic [AW-1:0] A_BYP   = AW'(14'h2000);

  logic [8:0]    cells_q;
  logic [1:0]    row_q, col_q, style_q;
  logic [CW-1:0] lit_q, unlit_q;
  logic          byp_q;

  wire wr_en = cs & wr;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cells_q <= '0;
      row_q   <= '0;
      col_q   <= '0;
      style_q <= '0;
      lit_q   <= CW'(12'h0F0);
      unlit_q <= '0;
      byp_q   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_CELLS: cells_q <= wdata[8:0];
        A_CURS:  begin row_q <= wdata[1:0]; col_q <= wdata[3:2]; end
        A_STYLE: style_q <= wdata[1:0];
        A_COLR:  begin lit_q <= wdata[CW-1:0]; unlit_q <= wdata[2*CW-1:CW]; end
        A_BYP:   byp_q <= wdata[0];
        default: ;
      endcase
    end
  end

  wire in_x = (x >= XW'(ORG_X)) && (x < XW'(ORG_X + SPAN));
  wire in_y = (y >= XW'(ORG_Y)) && (y < XW'(ORG_Y + SPAN));
  wire [XW-1:0] rx = x - XW'(ORG_X);
  wire [XW-1:0] ry = y - XW'(ORG_Y);

  logic [2:0]    hx, hy;
  logic [1:0]    cx, cy;
  logic [OW-1:0] ox, oy;

  always_comb begin
    hx = '0; hy = '0; cx = '0; cy = '0; ox = '0; oy = '0;
    for (int k = 0; k < 3; k++) begin
      if (rx >= XW'(k * PITCH + GAP) && rx < XW'((k + 1) * PITCH)) begin
        hx[k] = 1'b1;
        cx    = 2'(k);
        ox    = OW'(rx - XW'(k * PITCH + GAP));
      end
      if (ry >= XW'(k * PITCH + GAP) && ry < XW'((k + 1) * PITCH)) begin
        hy[k] = 1'b1;
        cy    = 2'(k);
        oy    = OW'(ry - XW'(k * PITCH + GAP));
      end
    end
  end

  logic          s1_in, s1_line;
  logic [1:0]    s1_r, s1_c;
  logic [OW-1:0] s1_ox, s1_oy;
  logic          s2_in;
  logic [CW-1:0] s2_rgb;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1_in <= 1'b0; s1_line <= 1'b0;
      s1_r  <= '0;   s1_c    <= '0;
      s1_ox <= '0;   s1_oy   <= '0;
    end else begin
      s1_in   <= in_x && in_y;
      s1_line <= (hx == 3'b000) || (hy == 3'b000);
      s1_r    <= cy;
      s1_c    <= cx;
      s1_ox   <= ox;
      s1_oy   <= oy;
    end
  end

  wire sel  = (row_q != 2'd3) && (col_q != 2'd3) && (s1_r == row_q) && (s1_c == col_q);
  wire ring = (s1_ox < OW'(RING)) || (s1_ox >= OW'(CELL - RING)) ||
              (s1_oy < OW'(RING)) || (s1_oy >= OW'(CELL - RING));
  wire dot  = (s1_ox >= OW'(DOT_LO)) && (s1_ox < OW'(DOT_HI)) &&
              (s1_oy >= OW'(DOT_LO)) && (s1_oy < OW'(DOT_HI));

  logic hl;
  always_comb begin
    case (style_q)
      2'd0:    hl = sel && ring;
      2'd1:    hl = sel;
      2'd2:    hl = sel && dot;
      default: hl = 1'b0;
    endcase
  end

  wire [3:0]  cidx      = {2'b00, s1_r} * 4'd3 + {2'b00, s1_c};
  wire [15:0] cell_bits = 16'(cells_q) >> cidx;
  wire [CW-1:0] gen = s1_line ? WHITE : hl ? RED : cell_bits[0] ? lit_q : unlit_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s2_in  <= 1'b0;
      s2_rgb <= '0;
    end else begin
      s2_in  <= s1_in;
      s2_rgb <= gen;
    end
  end

  assign pix_out = (byp_q || !s2_in) ? pix_in : s2_rgb;

  logic [1:0] age_q;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  function automatic logic in_win(logic [XW-1:0] px, logic [XW-1:0] py);
    return int'(px) >= ORG_X && int'(px) < ORG_X + SPAN &&
           int'(py) >= ORG_Y && int'(py) < ORG_Y + SPAN;
  endfunction

  function automatic logic on_gap(logic [XW-1:0] px, logic [XW-1:0] py);
    return ((int'(px) - ORG_X) % PITCH < GAP) || ((int'(py) - ORG_Y) % PITCH < GAP);
  endfunction

  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr) |=> $stable({cells_q, row_q, col_q, style_q, lit_q, unlit_q, byp_q})); // R2

  AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == A_BYP && wdata[0]) |=> (pix_out == pix_in)); // R4

  AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3 && !in_win($past(x, 2), $past(y, 2))) |-> (pix_out == pix_in)); // R5

  AST_LINE_WHITE: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3 && !byp_q && in_win($past(x, 2), $past(y, 2)) &&
     on_gap($past(x, 2), $past(y, 2))) |-> (pix_out == WHITE)); // R6

endmodule

// File: tb/tb_tile_grid_overlay.sv
module tb_tile_grid_overlay;
  logic        clk = 1'b0;
  logic        rst;
  logic [10:0] x, y;
  logic        cs, wr;
  logic [13:0] addr;
  logic [31:0] wdata;
  logic [11:0] pix_in, pix_out;

  tile_grid_overlay dut (.clk(clk), .rst(rst), .x(x), .y(y), .cs(cs), .wr(wr),
    .addr(addr), .wdata(wdata), .pix_in(pix_in), .pix_out(pix_out));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "";

  logic [8:0]  m_cells;
  logic [1:0]  m_row, m_col, m_style;
  logic [11:0] m_lit, m_unlit;
  logic        m_byp;
  int hx0, hy0, hx1, hy1, nh;

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_pix(int px, int py, logic [11:0] pin, output string tg);
    int rx, ry, r, c, ox, oy;
    logic sel, hl;
    if (m_byp) begin tg = "R4"; return pin; end
    if (px < 196 || px >= 444 || py < 116 || py >= 364) begin tg = "R5"; return pin; end
    rx = px - 196; ry = py - 116;
    if (rx % 82 < 2 || ry % 82 < 2) begin tg = "R6"; return 12'hFFF; end
    c = rx / 82; r = ry / 82; ox = rx % 82 - 2; oy = ry % 82 - 2;
    sel = (m_row != 3) && (m_col != 3) && (r == int'(m_row)) && (c == int'(m_col));
    hl = 1'b0;
    if (sel) begin
      case (m_style)
        2'd0: hl = (ox < 3 || ox > 76 || oy < 3 || oy > 76);
        2'd1: hl = 1'b1;
        2'd2: hl = (ox >= 32 && ox < 48 && oy >= 32 && oy < 48);
        default: hl = 1'b0;
      endcase
    end
    if (hl) begin tg = (m_style == 0) ? "R9" : (m_style == 1) ? "R10" : "R11"; return 12'hF00; end
    tg = "R7";
    return m_cells[r * 3 + c] ? m_lit : m_unlit;
  endfunction

  task automatic px(int nx, int ny);
    string tg;
    logic [11:0] e;
    @(negedge clk);
    x = 11'(nx); y = 11'(ny); pix_in = 12'($urandom);
    #1;
    if (nh >= 2) begin
      e = ref_pix(hx1, hy1, pix_in, tg);
      chk((cur_tag != "") ? cur_tag : tg, pix_out, e);
    end
    hx1 = hx0; hy1 = hy0; hx0 = nx; hy0 = ny; nh++;
  endtask

  task automatic flush();
    px(0, 0); px(0, 0);
  endtask

  task automatic wr_reg(logic [13:0] a, logic [31:0] d, bit c = 1, bit w = 1);
    @(negedge clk);
    cs = c; wr = w; addr = a; wdata = d;
    @(posedge clk); #1;
    cs = 0; wr = 0;
    nh = 0;
    if (c && w) begin
      case (a)
        14'd0: m_cells = d[8:0];
        14'd1: begin m_row = d[1:0]; m_col = d[3:2]; end
        14'd2: m_style = d[1:0];
        14'd3: begin m_lit = d[11:0]; m_unlit = d[23:12]; end
        14'h2000: m_byp = d[0];
        default: ;
      endcase
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog: actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; cs = 0; wr = 0; addr = '0; wdata = '0; x = '0; y = '0; pix_in = '0;
    m_cells = '0; m_row = 0; m_col = 0; m_style = 0; m_lit = 12'h0F0; m_unlit = 12'h000; m_byp = 0;
    nh = 0; hx0 = 0; hy0 = 0; hx1 = 0; hy1 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); x = 11'd300; y = 11'd200; pix_in = 12'h5A3; #1;
    chk("R1", pix_out, 12'h5A3);
    @(negedge clk); rst = 0;

    cur_tag = "R1";
    px(319, 240); px(198, 118); px(237, 157); px(403, 323); px(440, 200); flush();
    cur_tag = "R3";
    for (int i = 0; i < 12; i++) px((i % 2) ? 100 : 320, (i % 3) ? 240 : 150);
    flush();
    cur_tag = "";

    wr_reg(14'd0, 32'h1FF, 1, 0);
    wr_reg(14'd0, 32'h1FF, 0, 1);
    wr_reg(14'd5, 32'hFFFF_FFFF);
    wr_reg(14'h2001, 32'h1);
    cur_tag = "R2";
    px(320, 240); px(320, 240); px(160, 50); flush();
    cur_tag = "";

    wr_reg(14'd0, 32'h155);
    wr_reg(14'd3, {8'h0, 12'h812, 12'h3C5});
    wr_reg(14'd1, 32'h5);
    wr_reg(14'd2, 32'd0);
    for (int i = 0; i < 9; i++) px(238 + 82 * (i % 3), 158 + 82 * (i / 3));
    px(195, 200); px(196, 200); px(197, 200); px(198, 200);
    px(441, 200); px(442, 200); px(443, 200); px(444, 200);
    px(300, 115); px(300, 116); px(300, 363); px(300, 364);
    px(282, 240); px(283, 240); px(356, 240); px(357, 240);
    px(320, 202); px(320, 203); px(320, 278); px(320, 279);
    flush();
    wr_reg(14'd2, 32'd1);
    px(280, 200); px(361, 281); px(320, 240); px(362, 240); flush();
    wr_reg(14'd2, 32'd2);
    px(311, 240); px(312, 240); px(327, 240); px(328, 240);
    px(320, 231); px(320, 232); px(320, 247); px(320, 248); flush();
    wr_reg(14'd2, 32'd3);
    cur_tag = "R11";
    px(320, 240); px(282, 240); flush();
    cur_tag = "";
    wr_reg(14'd2, 32'd1);
    wr_reg(14'd1, 32'h7);
    cur_tag = "R8";
    px(320, 240); px(238, 240); px(402, 240); flush();
    wr_reg(14'd1, 32'hD);
    px(238, 158); px(320, 322); px(402, 322); flush();
    wr_reg(14'd1, 32'h8);
    px(402, 158); px(238, 158); flush();
    cur_tag = "";

    wr_reg(14'h2000, 32'h1);
    cur_tag = "R4";
    px(320, 240); px(197, 117); px(238, 158); px(20, 20); flush();
    cur_tag = "";
    wr_reg(14'h2000, 32'h0);

    for (int rnd = 0; rnd < 20; rnd++) begin
      wr_reg(14'd0, $urandom);
      wr_reg(14'd1, $urandom);
      wr_reg(14'd2, $urandom);
      wr_reg(14'd3, $urandom);
      wr_reg(14'h2000, (($urandom % 4) == 0) ? 32'h1 : 32'h0);
      for (int i = 0; i < 150; i++) begin
        if ((i % 10) == 0) px(int'($urandom % 1024), int'($urandom % 600));
        else px(186 + int'($urandom % 270), 106 + int'($urandom % 270));
      end
      flush();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule